// File: doc/BRIEF.md
# Cascadable Dual 16-bit Timer

This block holds two 16-bit up-counters. Each can run on its own as a periodic timer or as a counter of external clock edges, or the pair can be joined into a single 32-bit timer. A small word-wide register bus sets up the control, period and count registers. Dedicated pins carry an external clock, a gate and an idle indication for each timer, and the block drives level interrupt outputs and one-cycle trigger pulses.

When the pair is joined, the lower timer holds the low word and supplies the clock source, gate, prescaler and run control. The upper timer holds the high word and owns the flag, interrupt and trigger. A 16-bit holding register lets software read and write the full 32-bit count coherently through 16-bit accesses. Reading the low count word captures the high word in the holding register. Writing the low count word while joined copies the holding register into the high word.

Top module: `casc_timer_pair`

## Requirements
- R1: After reset both counts read 0, both periods read 0xFFFF, the flag register reads 0, and every interrupt and trigger output is low.
- R2: Register addresses are: 0 and 1 for the lower and upper control, 2 and 3 for the periods, 4 and 5 for the counts, 6 for the holding register and 7 for the flags. With control bit 0 (run) set, an unjoined timer on the internal clock advances once per cycle. When it advances while equal to its period it returns to 0 and sets its flag.
- R3: Control bits 4:3 pick a division of 1, 8, 64 or 256 (codes 0 to 3). Any write to a timer's control or count register restarts its prescaler from zero.
- R4: With control bit 2 (gate) set, the timer advances only while its synchronised gate input is high. A falling edge of the gate sets the timer's flag.
- R5: With control bit 1 (external source) set, the lower timer advances once per rising edge of its external clock, through a two-stage synchroniser.
- R6: With control bit 5 (stop in idle) set, counting halts while the idle input is high and resumes when it falls. With the bit clear, idle has no effect.
- R7: Bit 6 of the lower control register joins the pair. The 32-bit count then runs from the lower timer's clock, gate, prescaler and run bit, and carries from the low word into the high word. The upper control bits are ignored except bit 7.
- R8: When joined, a match of the 32-bit count with the 32-bit period returns the count to 0. It sets the upper flag only, and the upper interrupt output follows that flag when the upper control bit 7 (interrupt enable) is set.
- R9: A read of the lower count word loads the upper count word into the holding register in the same access. Later writes to the upper count do not change the holding register.
- R10: When joined, a write to the lower count word also loads the holding register contents into the upper count word.
- R11: The flags sit at bit 0 (lower) and bit 1 (upper) of address 7. They stay set until a 1 is written to that bit. Each interrupt output is its flag ANDed with that timer's bit 7.
- R12: Every period match produces exactly one single-cycle pulse on that timer's trigger output. When joined, the pulse appears on the upper trigger only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current address |
| ext_clk_lo | input | 1 | External count clock of the lower timer |
| ext_clk_hi | input | 1 | External count clock of the upper timer |
| gate_lo | input | 1 | Gate of the lower timer |
| gate_hi | input | 1 | Gate of the upper timer |
| idle | input | 1 | System idle indication |
| irq_lo | output | 1 | Lower timer interrupt |
| irq_hi | output | 1 | Upper timer interrupt |
| trig_lo | output | 1 | Lower timer match pulse |
| trig_hi | output | 1 | Upper timer match pulse |

## Verification
A stray prescaler count shows up at once in the final count of a short run, because the bench predicts the exact number of advances from the cycles between two control writes. A wrong carry or a wrong holding-register transfer shows up on the next read of the low word and the holding register. A misrouted flag shows up within one cycle of the match, on the flag read and on the interrupt and trigger pins.

// File: rtl/ctp_pkg.sv
package ctp_pkg;

   localparam logic [2:0] A_CTRL_LO = 3'd0;
   localparam logic [2:0] A_CTRL_HI = 3'd1;
   localparam logic [2:0] A_PER_LO  = 3'd2;
   localparam logic [2:0] A_PER_HI  = 3'd3;
   localparam logic [2:0] A_CNT_LO  = 3'd4;
   localparam logic [2:0] A_CNT_HI  = 3'd5;
   localparam logic [2:0] A_HOLD    = 3'd6;
   localparam logic [2:0] A_FLAGS   = 3'd7;

   localparam int CTRL_W = 8;

   typedef struct packed {
      logic       irq_en;
      logic       join_pair;
      logic       stop_idle;
      logic [1:0] presc;
      logic       gate_en;
      logic       ext_src;
      logic       run;
   } ctrl_t;

endpackage

// File: rtl/ctp_tick.sv
module ctp_tick #(
   parameter int SYNC_STAGES = 2,
   parameter int PRESC_W     = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       ext_src,
   input  logic       gate_en,
   input  logic [1:0] presc,
   input  logic       stop_idle,
   input  logic       idle,
   input  logic       ext_in,
   input  logic       gate_in,
   input  logic       presc_clr,
   output logic       tick,
   output logic       gate_fall
);

   if (SYNC_STAGES < 1 || SYNC_STAGES > 2) begin : g_bad_sync
      $error("ctp_tick: SYNC_STAGES must be 1 or 2");
   end
   if (PRESC_W < 8) begin : g_bad_presc
      $error("ctp_tick: PRESC_W must be at least 8");
   end

   logic ext_s, gate_s;
   logic ext_d, gate_d;

   if (SYNC_STAGES == 2) begin : g_sync2
      logic [1:0] e_sh, g_sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            e_sh <= '0;
            g_sh <= '0;
         end else begin
            e_sh <= {e_sh[0], ext_in};
            g_sh <= {g_sh[0], gate_in};
         end
      end
      assign ext_s  = e_sh[1];
      assign gate_s = g_sh[1];
   end else begin : g_sync1
      logic e_r, g_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            e_r <= 1'b0;
            g_r <= 1'b0;
         end else begin
            e_r <= ext_in;
            g_r <= gate_in;
         end
      end
      assign ext_s  = e_r;
      assign gate_s = g_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_d  <= 1'b0;
         gate_d <= 1'b0;
      end else begin
         ext_d  <= ext_s;
         gate_d <= gate_s;
      end
   end

   logic active, src_evt;
   logic [PRESC_W-1:0] pcnt, plim;

   assign active = run & ~(idle & stop_idle);

   always_comb begin
      if (ext_src)      src_evt = ext_s & ~ext_d;
      else if (gate_en) src_evt = gate_s;
      else              src_evt = 1'b1;
   end

   assign gate_fall = active & gate_en & ~ext_src & gate_d & ~gate_s;

   always_comb begin
      case (presc)
         2'd0:    plim = PRESC_W'(0);
         2'd1:    plim = PRESC_W'(7);
         2'd2:    plim = PRESC_W'(63);
         default: plim = PRESC_W'(255);
      endcase
   end

   assign tick = active & src_evt & (pcnt == plim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pcnt <= '0;
      else if (presc_clr)        pcnt <= '0;
      else if (active & src_evt) pcnt <= (pcnt == plim) ? '0 : pcnt + 1'b1;
   end

endmodule

// File: rtl/ctp_count.sv
module ctp_count #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          clr,
   input  logic          inc,
   output logic [CW-1:0] cnt
);

   if (CW < 2) begin : g_bad_cw
      $error("ctp_count: CW too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= load_val;
      else if (clr)  cnt <= '0;
      else if (inc)  cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/casc_timer_pair.sv
module casc_timer_pair
   import ctp_pkg::*;
#(
   parameter int CW      = 16,
   parameter int PRESC_W = 8,
   parameter int LO_SYNC = 2,
   parameter int HI_SYNC = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic          bus_re,
   input  logic [2:0]    bus_addr,
   input  logic [CW-1:0] bus_wdata,
   output logic [CW-1:0] bus_rdata,
   input  logic          ext_clk_lo,
   input  logic          ext_clk_hi,
   input  logic          gate_lo,
   input  logic          gate_hi,
   input  logic          idle,
   output logic          irq_lo,
   output logic          irq_hi,
   output logic          trig_lo,
   output logic          trig_hi
);

   localparam int PAD_C = CW - CTRL_W;
   localparam int PAD_F = CW - 2;

   if (CW < CTRL_W) begin : g_bad_width
      $error("casc_timer_pair: CW must hold a control word");
   end

   ctrl_t         ctrl_lo, ctrl_hi;
   logic [CW-1:0] per_lo, per_hi, hold;
   logic [CW-1:0] cnt_lo, cnt_hi;
   logic [1:0]    flags;
   logic          joined;

   logic wr_ctrl_lo, wr_ctrl_hi, wr_per_lo, wr_per_hi;
   logic wr_cnt_lo, wr_cnt_hi, wr_hold, wr_flags, rd_cnt_lo;

   assign wr_ctrl_lo = bus_we & (bus_addr == A_CTRL_LO);
   assign wr_ctrl_hi = bus_we & (bus_addr == A_CTRL_HI);
   assign wr_per_lo  = bus_we & (bus_addr == A_PER_LO);
   assign wr_per_hi  = bus_we & (bus_addr == A_PER_HI);
   assign wr_cnt_lo  = bus_we & (bus_addr == A_CNT_LO);
   assign wr_cnt_hi  = bus_we & (bus_addr == A_CNT_HI);
   assign wr_hold    = bus_we & (bus_addr == A_HOLD);
   assign wr_flags   = bus_we & (bus_addr == A_FLAGS);
   assign rd_cnt_lo  = bus_re & (bus_addr == A_CNT_LO);

   assign joined = ctrl_lo.join_pair;

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_lo <= '0;
         ctrl_hi <= '0;
         per_lo  <= '1;
         per_hi  <= '1;
      end else begin
         if (wr_ctrl_lo) ctrl_lo <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
         if (wr_ctrl_hi) ctrl_hi <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
         if (wr_per_lo)  per_lo  <= bus_wdata;
         if (wr_per_hi)  per_hi  <= bus_wdata;
      end
   end

   // count event sources
   logic tick_lo, tick_hi, gfall_lo, gfall_hi;

   ctp_tick #(.SYNC_STAGES(LO_SYNC), .PRESC_W(PRESC_W)) u_tick_lo (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (ctrl_lo.run),
      .ext_src   (ctrl_lo.ext_src),
      .gate_en   (ctrl_lo.gate_en),
      .presc     (ctrl_lo.presc),
      .stop_idle (ctrl_lo.stop_idle),
      .idle      (idle),
      .ext_in    (ext_clk_lo),
      .gate_in   (gate_lo),
      .presc_clr (wr_ctrl_lo | wr_cnt_lo),
      .tick      (tick_lo),
      .gate_fall (gfall_lo)
   );

   ctp_tick #(.SYNC_STAGES(HI_SYNC), .PRESC_W(PRESC_W)) u_tick_hi (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (ctrl_hi.run),
      .ext_src   (ctrl_hi.ext_src),
      .gate_en   (ctrl_hi.gate_en),
      .presc     (ctrl_hi.presc),
      .stop_idle (ctrl_hi.stop_idle),
      .idle      (idle),
      .ext_in    (ext_clk_hi),
      .gate_in   (gate_hi),
      .presc_clr (wr_ctrl_hi | wr_cnt_hi),
      .tick      (tick_hi),
      .gate_fall (gfall_hi)
   );

   // period compare and match routing
   logic lo_at_per, hi_at_per, lo_full;
   logic match32, match_lo, match_hi;

   assign lo_at_per = (cnt_lo == per_lo);
   assign hi_at_per = (cnt_hi == per_hi);
   assign lo_full   = &cnt_lo;
   assign match32   = joined  & tick_lo & lo_at_per & hi_at_per;
   assign match_lo  = ~joined & tick_lo & lo_at_per;
   assign match_hi  = ~joined & tick_hi & hi_at_per;

   logic          hi_load, hi_inc;
   logic [CW-1:0] hi_val;

   assign hi_load = wr_cnt_hi | (joined & wr_cnt_lo);
   assign hi_val  = (joined & wr_cnt_lo) ? hold : bus_wdata;
   assign hi_inc  = joined ? (tick_lo & lo_full) : tick_hi;

   ctp_count #(.CW(CW)) u_cnt_lo (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_cnt_lo),
      .load_val (bus_wdata),
      .clr      (match32 | match_lo),
      .inc      (tick_lo),
      .cnt      (cnt_lo)
   );

   ctp_count #(.CW(CW)) u_cnt_hi (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (hi_load),
      .load_val (hi_val),
      .clr      (match32 | match_hi),
      .inc      (hi_inc),
      .cnt      (cnt_hi)
   );

   // holding register for coherent 32-bit access
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hold <= '0;
      else if (wr_hold)   hold <= bus_wdata;
      else if (rd_cnt_lo) hold <= cnt_hi;
   end

   // flags and trigger pulses
   logic [1:0] flag_set, flag_clr;

   assign flag_set[0] = match_lo | (~joined & gfall_lo);
   assign flag_set[1] = match_hi | match32 | (joined & gfall_lo) | (~joined & gfall_hi);
   assign flag_clr    = wr_flags ? bus_wdata[1:0] : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags   <= '0;
         trig_lo <= 1'b0;
         trig_hi <= 1'b0;
      end else begin
         flags   <= (flags & ~flag_clr) | flag_set;
         trig_lo <= match_lo;
         trig_hi <= match_hi | match32;
      end
   end

   assign irq_lo = flags[0] & ctrl_lo.irq_en;
   assign irq_hi = flags[1] & ctrl_hi.irq_en;

   // read mux
   always_comb begin
      case (bus_addr)
         A_CTRL_LO: bus_rdata = {{PAD_C{1'b0}}, ctrl_lo};
         A_CTRL_HI: bus_rdata = {{PAD_C{1'b0}}, ctrl_hi};
         A_PER_LO:  bus_rdata = per_lo;
         A_PER_HI:  bus_rdata = per_hi;
         A_CNT_LO:  bus_rdata = cnt_lo;
         A_CNT_HI:  bus_rdata = cnt_hi;
         A_HOLD:    bus_rdata = hold;
         default:   bus_rdata = {{PAD_F{1'b0}}, flags};
      endcase
   end

endmodule

// File: rtl/ctp_chk.sv
module ctp_chk
   import ctp_pkg::*;
#(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_we,
   input logic          bus_re,
   input logic [2:0]    bus_addr,
   input logic [CW-1:0] bus_wdata,
   input logic [CW-1:0] cnt_lo,
   input logic [CW-1:0] cnt_hi,
   input logic [CW-1:0] hold,
   input logic [1:0]    flags,
   input ctrl_t         ctrl_lo,
   input logic          trig_lo,
   input logic          trig_hi
);

   // R9
   hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && !bus_we && bus_addr == A_CNT_LO) |=> hold == $past(cnt_hi));

   // R10
   joined_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_CNT_LO && ctrl_lo.join_pair) |=> cnt_hi == $past(hold));

   // R11
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[1] && !(bus_we && bus_addr == A_FLAGS && bus_wdata[1])) |=> flags[1]);

   // R12
   trig_hi_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_hi |-> flags[1]);

   // R12
   trig_lo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_lo |-> flags[0]);

   // R8
   joined_lo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctrl_lo.join_pair) |-> !trig_lo);

   // R2
   halted_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_lo.run && !(bus_we && bus_addr == A_CNT_LO)) |=> $stable(cnt_lo));

endmodule

bind casc_timer_pair ctp_chk #(.CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_re    (bus_re),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .cnt_lo    (cnt_lo),
   .cnt_hi    (cnt_hi),
   .hold      (hold),
   .flags     (flags),
   .ctrl_lo   (ctrl_lo),
   .trig_lo   (trig_lo),
   .trig_hi   (trig_hi)
);

// File: tb/casc_timer_pair_tb_top.sv
module casc_timer_pair_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0, bus_re = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        ext_clk_lo = 1'b0, ext_clk_hi = 1'b0;
   logic        gate_lo = 1'b0, gate_hi = 1'b0, idle = 1'b0;
   logic        irq_lo, irq_hi, trig_lo, trig_hi;

   int n_chk = 0, n_err = 0;
   int trig_lo_n = 0, trig_hi_n = 0;
   bit done = 1'b0;

   logic [15:0] exp_q[$];
   string       tag_q[$];
   event        smp_ev;

   always #10 clk = ~clk;

   casc_timer_pair dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ext_clk_lo(ext_clk_lo), .ext_clk_hi(ext_clk_hi),
      .gate_lo(gate_lo), .gate_hi(gate_hi), .idle(idle),
      .irq_lo(irq_lo), .irq_hi(irq_hi), .trig_lo(trig_lo), .trig_hi(trig_hi)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data as the design presents it
   always @(smp_ev) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(32'(bus_rdata), 32'(e), t);
   end

   always @(negedge clk) begin
      if (trig_lo) trig_lo_n++;
      if (trig_hi) trig_hi_n++;
   end

   // all tasks start and end at a falling edge
   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
      bus_re = 1'b1; bus_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      #5 -> smp_ev;
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   // ticks = n on the internal clock at division 1
   task automatic run_for(input logic [2:0] a, input logic [15:0] on, input logic [15:0] off, input int n);
      wr(a, on);
      repeat (n - 1) @(negedge clk);
      wr(a, off);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog all-requirements actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd4, 16'h0000, "R1 lower count");
      rd(3'd3, 16'hFFFF, "R1 upper period");
      rd(3'd7, 16'h0000, "R1 flags");
      chk({irq_lo, irq_hi, trig_lo, trig_hi}, 0, "R1 outputs");

      // R2 R11 R12 lower timer wraps at period 4 after 7 ticks
      wr(3'd2, 16'd4);
      run_for(3'd0, 16'h0081, 16'h0080, 7);
      rd(3'd4, 16'd2, "R2 lower wrap count");
      rd(3'd7, 16'h0001, "R2 lower flag");
      chk(irq_lo, 1, "R11 lower irq");
      chk(trig_lo_n, 1, "R12 lower trigger pulses");
      wr(3'd7, 16'h0001);
      rd(3'd7, 16'h0000, "R11 flag clear");
      chk(irq_lo, 0, "R11 irq released");

      // R3 prescaler by 8 and restart on control write
      wr(3'd2, 16'hFFFF);
      wr(3'd4, 16'd0);
      run_for(3'd0, 16'h0009, 16'h0008, 20);
      rd(3'd4, 16'd2, "R3 divide by 8");
      wr(3'd4, 16'd0);
      run_for(3'd0, 16'h0009, 16'h0008, 5);
      run_for(3'd0, 16'h0009, 16'h0008, 5);
      rd(3'd4, 16'd0, "R3 prescaler restart");

      // R4 gated counting
      wr(3'd4, 16'd0);
      wr(3'd0, 16'h0005);
      repeat (5) @(negedge clk);
      gate_lo = 1'b1;
      repeat (6) @(negedge clk);
      gate_lo = 1'b0;
      repeat (4) @(negedge clk);
      wr(3'd0, 16'h0004);
      rd(3'd4, 16'd6, "R4 gated count");
      rd(3'd7, 16'h0001, "R4 gate fall flag");
      wr(3'd7, 16'h0003);

      // R5 external clock edges
      wr(3'd4, 16'd0);
      wr(3'd0, 16'h0003);
      for (int i = 0; i < 5; i++) begin
         ext_clk_lo = 1'b1; repeat (2) @(negedge clk);
         ext_clk_lo = 1'b0; repeat (2) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      wr(3'd0, 16'h0002);
      rd(3'd4, 16'd5, "R5 external edges");

      // R6 stop in idle, then resume
      wr(3'd4, 16'd0);
      idle = 1'b1;
      wr(3'd0, 16'h0021);
      repeat (3) @(negedge clk);
      idle = 1'b0;
      repeat (4) @(negedge clk);
      wr(3'd0, 16'h0020);
      rd(3'd4, 16'd5, "R6 halt and resume");
      wr(3'd4, 16'd0);
      idle = 1'b1;
      run_for(3'd0, 16'h0001, 16'h0000, 6);
      idle = 1'b0;
      rd(3'd4, 16'd6, "R6 idle ignored");

      // R7 R9 R10 joined 32-bit access and carry
      wr(3'd0, 16'h0040);
      wr(3'd1, 16'h0098);
      wr(3'd6, 16'h1234);
      wr(3'd4, 16'hFFFE);
      rd(3'd4, 16'hFFFE, "R10 low word");
      rd(3'd6, 16'h1234, "R10 high word via hold");
      rd(3'd5, 16'h1234, "R10 high word direct");
      wr(3'd2, 16'hFFFF);
      wr(3'd3, 16'hFFFF);
      run_for(3'd0, 16'h0041, 16'h0040, 3);
      rd(3'd4, 16'h0001, "R7 low after carry");
      rd(3'd6, 16'h1235, "R7 high after carry");
      wr(3'd5, 16'h5555);
      rd(3'd6, 16'h1235, "R9 hold unchanged");

      // R8 R12 joined match
      wr(3'd7, 16'h0003);
      trig_lo_n = 0; trig_hi_n = 0;
      wr(3'd3, 16'h0001);
      wr(3'd2, 16'h0002);
      wr(3'd6, 16'h0001);
      wr(3'd4, 16'h0000);
      run_for(3'd0, 16'h0041, 16'h0040, 4);
      rd(3'd4, 16'h0001, "R8 low after 32-bit match");
      rd(3'd6, 16'h0000, "R8 high after 32-bit match");
      rd(3'd7, 16'h0002, "R8 upper flag only");
      chk({irq_hi, irq_lo}, 2'b10, "R8 upper irq");
      chk(trig_hi_n, 1, "R12 joined upper pulses");
      chk(trig_lo_n, 0, "R12 joined lower quiet");
      wr(3'd7, 16'h0002);
      rd(3'd7, 16'h0000, "R11 upper flag clear");
      chk(irq_hi, 0, "R11 upper irq released");

      // R2 R12 upper timer alone
      wr(3'd0, 16'h0000);
      wr(3'd5, 16'd0);
      wr(3'd3, 16'd2);
      run_for(3'd1, 16'h0081, 16'h0080, 7);
      rd(3'd5, 16'd1, "R2 upper wrap count");
      rd(3'd7, 16'h0002, "R2 upper flag");
      chk(trig_hi_n, 3, "R12 upper pulses");

      repeat (2) @(negedge clk);
      chk(exp_q.size(), 0, "R2 scoreboard drained");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule